// File: doc/BRIEF.md
# Eight-bit arithmetic and logic unit with a chained right shift

This block is a purely combinational arithmetic and logic unit for an eight-bit datapath. Two operands, X and Y, and a carry input arrive from the register file or the memory path. A three-bit operation code chooses one of eight functions. There are three additions and subtractions that can take the carry, three bitwise logic functions, and two moves that forward one operand unchanged.

After the operation, a two-bit shift code can shift the result one bit to the right, either logically or arithmetically. The shifted value is what the block returns. The carry output comes from the arithmetic stage and the shift does not touch it. The zero output looks at the final shifted value.

The block holds no state. The surrounding control logic drives the inputs and captures the outputs in the same cycle. There is no state machine here, because the block has no sequence of its own.

Top module: `alu8_postshift`

## Requirements
- R1: Operation code 000 returns X + Y, truncated to 8 bits. Carry out is the ninth bit of that sum.
- R2: Operation code 001 returns X + Y + carry_i, truncated to 8 bits. Carry out is the ninth bit of that sum.
- R3: Operation code 010 returns X - (Y + carry_i) modulo 256. Carry out is 1 exactly when Y + carry_i is greater than X.
- R4: Operation code 011 returns X unchanged and operation code 111 returns Y unchanged. Both force carry out to 0.
- R5: Operation codes 100, 101 and 110 return bitwise XOR, OR and AND of X and Y. All three force carry out to 0.
- R6: Shift code 01 shifts the operation result right by one bit and fills bit 7 with 0.
- R7: Shift code 10 shifts the operation result right by one bit and copies the old bit 7 into bit 7.
- R8: Shift code 00 returns the operation result unshifted, and shift code 11 gives the same output as 00.
- R9: zero_o is 1 exactly when the final 8-bit result after the shift is 0.
- R10: The shift code never changes carry_o. Carry out for any shift code equals carry out for shift code 00 with the same operands and operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 8 | Operand X |
| opb_i | input | 8 | Operand Y |
| carry_i | input | 1 | Carry input; used by codes 001 and 010 |
| op_i | input | 3 | Operation code |
| shift_i | input | 2 | Post-shift code |
| result_o | output | 8 | Final result after the shift |
| carry_o | output | 1 | Carry or borrow from the operation stage |
| zero_o | output | 1 | Set when result_o is 0 |

## Verification
The checker evaluates its properties only when every input is a known 0 or 1. It therefore assumes the inputs are always fully driven. The bench keeps to that assumption: it drives known values from time zero, including during its reset phase, and it changes them only at a fixed offset after a clock edge. The checks therefore read settled combinational outputs. Operand values cover the corners that matter for carry and borrow: 0, 0x7F, 0x80 and 0xFF, each combined with both carry inputs. These run under all eight operation codes and all four shift codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_ADC  = 3'b001,
        OP_SBB  = 3'b010,
        OP_MOVX = 3'b011,
        OP_XOR  = 3'b100,
        OP_OR   = 3'b101,
        OP_AND  = 3'b110,
        OP_MOVY = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_NONE = 2'b00,
        SH_LSR  = 2'b01,
        SH_ASR  = 2'b10,
        SH_RSV  = 2'b11
    } alu_shift_e;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    input  alu_op_e          op_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0] ext_sum;
    logic [EXT-1:0] ext_diff;
    logic           add_cin;

    // Only the add-with-carry form consumes the carry input on the adder.
    assign add_cin  = (op_i == OP_ADC) ? cin_i : 1'b0;
    assign ext_sum  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, add_cin};
    // Borrow lands in the extra bit: X - Y - c is at least -2^WIDTH.
    assign ext_diff = {1'b0, a_i} - {1'b0, b_i} - {{WIDTH{1'b0}}, cin_i};

    always_comb begin
        if (op_i == OP_SBB) begin
            sum_o  = ext_diff[WIDTH-1:0];
            cout_o = ext_diff[WIDTH];
        end else begin
            sum_o  = ext_sum[WIDTH-1:0];
            cout_o = ext_sum[WIDTH];
        end
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  alu_op_e          op_i,
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_MOVX: res_o = a_i;
            OP_MOVY: res_o = b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_AND:  res_o = a_i & b_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] din_i,
    input  alu_shift_e       mode_i,
    output logic [WIDTH-1:0] dout_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] shifted;
    logic             fill_bit;

    assign fill_bit = (mode_i == SH_ASR) ? din_i[MSB] : 1'b0;

    generate
        for (genvar i = 0; i < MSB; i++) begin : g_lane
            assign shifted[i] = din_i[i+1];
        end
    endgenerate
    assign shifted[MSB] = fill_bit;

    always_comb begin
        unique case (mode_i)
            SH_LSR, SH_ASR: dout_o = shifted;
            default:        dout_o = din_i;
        endcase
    end
endmodule

// File: rtl/alu8_postshift.sv
module alu8_postshift
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             carry_i,
    input  logic [2:0]       op_i,
    input  logic [1:0]       shift_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             zero_o
);
    alu_op_e          op_sel;
    alu_shift_e       sh_sel;
    logic [WIDTH-1:0] arith_res;
    logic             arith_cout;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] pre_shift;
    logic             is_arith;

    assign op_sel   = alu_op_e'(op_i);
    assign sh_sel   = alu_shift_e'(shift_i);
    assign is_arith = (op_sel == OP_ADD) || (op_sel == OP_ADC) || (op_sel == OP_SBB);

    alu8_arith #(.WIDTH(WIDTH)) u_arith (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .cin_i  (carry_i),
        .op_i   (op_sel),
        .sum_o  (arith_res),
        .cout_o (arith_cout)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .op_i  (op_sel),
        .res_o (logic_res)
    );

    assign pre_shift = is_arith ? arith_res : logic_res;
    assign carry_o   = is_arith ? arith_cout : 1'b0;

    alu8_shift #(.WIDTH(WIDTH)) u_shift (
        .din_i  (pre_shift),
        .mode_i (sh_sel),
        .dout_o (result_o)
    );

    assign zero_o = ~|result_o;
endmodule

// File: rtl/alu8_postshift_chk.sv
module alu8_postshift_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic             carry_i,
    input logic [2:0]       op_i,
    input logic [1:0]       shift_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o,
    input logic             zero_o
);
    logic known;
    assign known = !$isunknown({opa_i, opb_i, carry_i, op_i, shift_i});

    always_comb begin
        if (known) begin
            // R4: both moves return no carry
            assert_move_no_carry_R4: assert (!((op_i == 3'b011 || op_i == 3'b111) && carry_o));
            // R4: move of X with no shift is transparent
            assert_movx_pass_R4: assert (!(op_i == 3'b011 && shift_i == 2'b00) || result_o == opa_i);
            // R5: bitwise operations return no carry
            assert_logic_no_carry_R5: assert (!(op_i[2] && op_i != 3'b111 && carry_o));
            // R6: logical shift clears the top bit
            assert_lsr_top_clear_R6: assert (!(shift_i == 2'b01) || !result_o[WIDTH-1]);
            // R7: arithmetic shift of a moved X keeps its sign
            assert_asr_sign_R7: assert (!(shift_i == 2'b10 && op_i == 3'b011) || result_o[WIDTH-1] == opa_i[WIDTH-1]);
            // R9: zero flag agrees with the returned value
            assert_zero_flag_R9: assert (zero_o == (result_o == '0));
        end
    end
endmodule

bind alu8_postshift alu8_postshift_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu8_postshift_bench.sv
module alu8_postshift_bench;
    localparam int W = 8;

    typedef struct {
        logic [7:0] res;
        logic       cy;
        logic       z;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opa = '0;
    logic [7:0] opb = '0;
    logic       cin = 1'b0;
    logic [2:0] op  = '0;
    logic [1:0] sh  = '0;
    logic [7:0] res;
    logic       cy;
    logic       z;

    int   checks   = 0;
    int   failures = 0;
    exp_t sb_q[$];
    bit   done     = 0;

    always #2.5 clk = ~clk;

    alu8_postshift #(.WIDTH(W)) u_alu8_postshift (
        .opa_i(opa), .opb_i(opb), .carry_i(cin), .op_i(op), .shift_i(sh),
        .result_o(res), .carry_o(cy), .zero_o(z)
    );

    function automatic string tag_of(input logic [2:0] o, input logic [1:0] s);
        string t;
        case (o)
            3'b000: t = "R1";
            3'b001: t = "R2";
            3'b010: t = "R3";
            3'b011, 3'b111: t = "R4";
            default: t = "R5";
        endcase
        case (s)
            2'b01: t = {t, "/R6/R10"};
            2'b10: t = {t, "/R7/R10"};
            default: t = {t, "/R8"};
        endcase
        return {t, "/R9"};
    endfunction

    function automatic exp_t model(input logic [7:0] x, input logic [7:0] y,
                                   input logic c, input logic [2:0] o, input logic [1:0] s);
        exp_t e;
        int   t;
        logic [7:0] r;
        logic k;
        k = 1'b0;
        case (o)
            3'b000: begin t = int'(x) + int'(y);        r = t[7:0]; k = (t > 255); end
            3'b001: begin t = int'(x) + int'(y) + int'(c); r = t[7:0]; k = (t > 255); end
            3'b010: begin t = int'(x) - int'(y) - int'(c); r = t[7:0]; k = (t < 0); end
            3'b011: r = x;
            3'b100: r = x ^ y;
            3'b101: r = x | y;
            3'b110: r = x & y;
            default: r = y;
        endcase
        if (s == 2'b01) r = {1'b0, r[7:1]};
        else if (s == 2'b10) r = {r[7], r[7:1]};
        e.res = r; e.cy = k; e.z = (r == 8'h00); e.tag = tag_of(o, s);
        return e;
    endfunction

    task automatic drive(input logic [7:0] x, input logic [7:0] y, input logic c,
                         input logic [2:0] o, input logic [1:0] s, input string extra);
        exp_t e;
        @(posedge clk);
        #1;
        opa = x; opb = y; cin = c; op = o; sh = s;
        e = model(x, y, c, o, s);
        if (extra != "") e.tag = {extra, " ", e.tag};
        sb_q.push_back(e);
    endtask

    // Monitor: one expected item per cycle, compared mid-cycle
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (res !== e.res || cy !== e.cy || z !== e.z) begin
                failures++;
                $display("FAIL %s: got res=%02h cy=%0b z=%0b expected res=%02h cy=%0b z=%0b",
                         e.tag, res, cy, z, e.res, e.cy, e.z);
            end
        end
    end

    initial begin
        #50000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] corners [4];
        corners[0] = 8'h00; corners[1] = 8'h7F; corners[2] = 8'h80; corners[3] = 8'hFF;
        repeat (3) @(posedge clk);
        // Reset-phase state: zero inputs give a zero result, R9
        @(negedge clk);
        checks++;
        if (res !== 8'h00 || cy !== 1'b0 || z !== 1'b1) begin
            failures++;
            $display("FAIL R9 reset: got res=%02h cy=%0b z=%0b expected res=00 cy=0 z=1", res, cy, z);
        end
        rst = 1'b0;

        // Directed corners
        drive(8'hC8, 8'h64, 1'b0, 3'b000, 2'b00, "R1 carry");
        drive(8'hFF, 8'h00, 1'b1, 3'b001, 2'b00, "R2 wrap-to-zero");
        drive(8'h05, 8'h05, 1'b0, 3'b010, 2'b00, "R3 equal");
        drive(8'h05, 8'h05, 1'b1, 3'b010, 2'b00, "R3 borrow by carry");
        drive(8'h00, 8'hFF, 1'b1, 3'b010, 2'b00, "R3 max borrow");
        drive(8'hC8, 8'h64, 1'b0, 3'b000, 2'b01, "R10 carry kept");
        drive(8'h81, 8'h00, 1'b0, 3'b011, 2'b10, "R7 sign fill");
        drive(8'h81, 8'h00, 1'b0, 3'b011, 2'b01, "R6 zero fill");
        drive(8'h81, 8'h00, 1'b0, 3'b011, 2'b11, "R8 reserved");
        drive(8'h01, 8'h00, 1'b0, 3'b011, 2'b01, "R9 shifted out");
        drive(8'h12, 8'hA5, 1'b1, 3'b111, 2'b00, "R4 move Y");
        drive(8'hF0, 8'h3C, 1'b1, 3'b100, 2'b00, "R5 xor");

        // Sweep: every op and shift over the corner operands
        for (int o = 0; o < 8; o++)
            for (int s = 0; s < 4; s++)
                for (int i = 0; i < 4; i++)
                    for (int j = 0; j < 4; j++)
                        for (int c = 0; c < 2; c++)
                            drive(corners[i], corners[j], c[0], o[2:0], s[1:0], "");

        // Patterned operands
        for (int n = 0; n < 256; n++)
            drive(8'(n * 37 + 11), 8'(n * 91 + 5), n[0], 3'(n), 2'(n >> 3), "pattern");

        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule